// File: doc/BRIEF.md
# Binary Code Modulation LED Driver

The block dims 32 LED channels through an external chain of serial-in, parallel-out shift registers. Each channel has a brightness word written through a simple write port. The block stores only the significant part of each word and regroups the stored values into bit planes. A plane is one word per bit weight, and bit `j` of that word belongs to channel `j`. The planes are sent to the register chain one after another, from the lowest weight to the highest.

Each bit period has two parts. The first is a data cycle. The plane is shifted out on a serial clock and data pair, and a strobe latches it into the register outputs. The outputs then hold for a time that grows with the bit weight. The second part is a short clear cycle, which pulses a clear line to blank the outputs. The length of every period is fixed by the bit index alone, so the frame rate and the duty cycle do not depend on the brightness data. The clock domain uses one timer tick per clock cycle.

Top module: `bcm_led_driver`

## Requirements
- R1: While `rst_ni` is low, all four outputs are low and every stored brightness is zero. After release, the sequence starts with plane 0.
- R2: A cycle with `wr_en_i` high stores `wr_data_i[15:2]` for channel `wr_ch_i`. Bits 1:0 of the word have no effect on any output.
- R3: Bit `j` of plane `i` (i = 0..13) equals bit `i+2` of the 16-bit word last written to channel `j`.
- R4: Each data cycle shifts 32 bits, one per two-tick serial clock period. `sdo_o` changes only while `sclk_o` is low, and the receiver samples on the rising edge. Plane bits 15..0 go out first, then bits 31..16, in descending bit order.
- R5: Planes are sent in the order 0, 1, …, 13, and the sequence then returns to 0.
- R6: The data cycle of plane `i` lasts `122 + (BASE_TICKS << i)` ticks, with `BASE_TICKS` = 4 by default. The strobe is high from data tick 120 to the end of the data cycle, which is `2 + (BASE_TICKS << i)` ticks.
- R7: Each clear cycle lasts 40 ticks. `clear_o` is high for exactly one tick and rises one tick after `strobe_o` falls. The two outputs are never high together.
- R8: One full frame of 14 periods lasts `14*162 + BASE_TICKS*(2^14-1)` ticks, whatever the brightness data.
- R9: A plane is captured at tick 0 of its data cycle. A write made while that plane is being shifted does not change it. The write takes effect from the next captured plane.
- R10: `sclk_o` is never high while `strobe_o` is high, and all 32 serial clock rises of a plane come before its strobe rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock; one tick per cycle |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Brightness write strobe |
| wr_ch_i | input | 5 | Channel index of the write |
| wr_data_i | input | 16 | Brightness word; the upper 14 bits are used |
| sclk_o | output | 1 | Serial clock to the register chain (idle low) |
| sdo_o | output | 1 | Serial data to the register chain |
| strobe_o | output | 1 | Output latch strobe, active high |
| clear_o | output | 1 | Output clear pulse, active high |

## Verification
There are two pairs of events that can meet in the same cycle.

The first pair is a brightness write and the shifting of a plane. The bench waits for the end of a clear pulse and counts forward into the next shift window. There it writes one channel so that the bit in the plane now being shifted is inverted, and the bit in the following plane is inverted as well. The plane being shifted must match the old value, and the next plane must show the new one.

The second pair is the end of the strobe and the clear pulse. The bench measures the gap between the strobe falling and the clear rising, and the width of the clear pulse, for every plane. It also counts any cycle in which both outputs are high, or in which the serial clock is high under the strobe.

// File: rtl/bcm_pkg.sv
package bcm_pkg;
  typedef enum logic {
    PH_DATA  = 1'b0,
    PH_CLEAR = 1'b1
  } phase_e;
endpackage

// File: rtl/bcm_plane_store.sv
module bcm_plane_store #(
  parameter int N_CH   = 32,
  parameter int WORD_W = 16,
  parameter int N_BITS = 14,
  localparam int CH_W  = $clog2(N_CH)
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          wr_en_i,
  input  logic [CH_W-1:0]               wr_ch_i,
  input  logic [WORD_W-1:0]             wr_data_i,
  output logic [N_BITS-1:0][N_CH-1:0]   planes_o
);
  localparam int DROP_W = WORD_W - N_BITS;

  logic [N_CH-1:0][N_BITS-1:0] level_q;
  logic                        unused_low;

  assign unused_low = ^wr_data_i[DROP_W-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      level_q <= '0;
    end else if (wr_en_i) begin
      level_q[wr_ch_i] <= wr_data_i[WORD_W-1 -: N_BITS];
    end
  end

  // transpose: plane b gathers bit b of every channel
  for (genvar b = 0; b < N_BITS; b++) begin : g_plane
    for (genvar c = 0; c < N_CH; c++) begin : g_ch
      assign planes_o[b][c] = level_q[c][b];
    end
  end

  // R2
  store_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |=> level_q[$past(wr_ch_i)] == $past(wr_data_i[WORD_W-1 -: N_BITS]));
endmodule

// File: rtl/bcm_sequencer.sv
module bcm_sequencer
  import bcm_pkg::*;
#(
  parameter int N_BITS      = 14,
  parameter int SHIFT_TICKS = 120,
  parameter int DATA_EXTRA  = 2,
  parameter int BASE_TICKS  = 4,
  parameter int CLR_TICKS   = 40,
  localparam int BIT_W      = $clog2(N_BITS),
  localparam int MAX_LEN    = SHIFT_TICKS + DATA_EXTRA + (BASE_TICKS << (N_BITS - 1)),
  localparam int CNT_W      = $clog2(MAX_LEN + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  output phase_e           phase_o,
  output logic [CNT_W-1:0] tick_o,
  output logic [BIT_W-1:0] bit_o,
  output logic             load_o
);
  phase_e           phase_q;
  logic [CNT_W-1:0] tick_q;
  logic [BIT_W-1:0] bit_q;
  logic [CNT_W-1:0] data_last;
  logic [BIT_W-1:0] bit_next;

  always_comb begin
    data_last = CNT_W'(SHIFT_TICKS + DATA_EXTRA - 1) + (CNT_W'(BASE_TICKS) << bit_q);
    bit_next  = (bit_q == BIT_W'(N_BITS - 1)) ? '0 : bit_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= PH_DATA;
      tick_q  <= '0;
      bit_q   <= '0;
    end else if (phase_q == PH_DATA) begin
      if (tick_q == data_last) begin
        phase_q <= PH_CLEAR;
        tick_q  <= '0;
      end else begin
        tick_q <= tick_q + 1'b1;
      end
    end else begin
      if (tick_q == CNT_W'(CLR_TICKS - 1)) begin
        phase_q <= PH_DATA;
        tick_q  <= '0;
        bit_q   <= bit_next;
      end else begin
        tick_q <= tick_q + 1'b1;
      end
    end
  end

  assign phase_o = phase_q;
  assign tick_o  = tick_q;
  assign bit_o   = bit_q;
  assign load_o  = (phase_q == PH_DATA) && (tick_q == '0);

  // R5
  bit_order_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bit_q != $past(bit_q)) |->
      (bit_q == (($past(bit_q) == BIT_W'(N_BITS - 1)) ? '0 : $past(bit_q) + 1'b1)));

  // R7
  clear_len_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_q == PH_CLEAR) |-> (tick_q < CNT_W'(CLR_TICKS)));

  // R5
  bit_switch_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bit_q != $past(bit_q)) |-> (phase_q == PH_DATA && tick_q == '0));
endmodule

// File: rtl/bcm_shifter.sv
module bcm_shifter
  import bcm_pkg::*;
#(
  parameter int N_CH   = 32,
  parameter int N_BITS = 14,
  parameter int CNT_W  = 16,
  localparam int CH_W  = $clog2(N_CH),
  localparam int BIT_W = $clog2(N_BITS),
  localparam int HALF  = N_CH / 2,
  localparam int SHIFT_LEN = 2 * N_CH
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        load_i,
  input  logic [BIT_W-1:0]            bit_i,
  input  logic [N_BITS-1:0][N_CH-1:0] planes_i,
  input  phase_e                      phase_i,
  input  logic [CNT_W-1:0]            tick_i,
  output logic                        sclk_o,
  output logic                        sdo_o
);
  logic [N_CH-1:0] plane_q;
  logic [CH_W:0]   rel;
  logic [CH_W-1:0] k_w;
  logic [CH_W-1:0] idx_w;
  logic            in_win;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      plane_q <= '0;
    end else if (load_i) begin
      plane_q <= planes_i[bit_i];
    end
  end

  // shift window: data ticks 1..SHIFT_LEN, two ticks per bit
  always_comb begin
    in_win = (phase_i == PH_DATA) && (tick_i != '0) && (tick_i <= CNT_W'(SHIFT_LEN));
    rel    = (CH_W + 1)'(tick_i - 1'b1);
    k_w    = rel[CH_W:1];
    // low half first, each half MSB first
    if (k_w < CH_W'(HALF)) idx_w = CH_W'(HALF - 1) - k_w;
    else                   idx_w = CH_W'(N_CH - 1) - (k_w - CH_W'(HALF));
    sclk_o = in_win && rel[0];
    sdo_o  = in_win && plane_q[idx_w];
  end

  // R9
  plane_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_i == PH_DATA && tick_i != '0 && $past(!load_i)) |-> $stable(plane_q));
endmodule

// File: rtl/bcm_led_driver.sv
module bcm_led_driver
  import bcm_pkg::*;
#(
  parameter int N_CH        = 32,
  parameter int WORD_W      = 16,
  parameter int N_BITS      = 14,
  parameter int SHIFT_TICKS = 120,
  parameter int DATA_EXTRA  = 2,
  parameter int BASE_TICKS  = 4,
  parameter int CLR_TICKS   = 40,
  parameter int DEAD_TICKS  = 1,
  localparam int CH_W       = $clog2(N_CH),
  localparam int BIT_W      = $clog2(N_BITS),
  localparam int MAX_LEN    = SHIFT_TICKS + DATA_EXTRA + (BASE_TICKS << (N_BITS - 1)),
  localparam int CNT_W      = $clog2(MAX_LEN + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [CH_W-1:0]   wr_ch_i,
  input  logic [WORD_W-1:0] wr_data_i,
  output logic              sclk_o,
  output logic              sdo_o,
  output logic              strobe_o,
  output logic              clear_o
);
  logic [N_BITS-1:0][N_CH-1:0] planes;
  phase_e                      phase;
  logic [CNT_W-1:0]            tick;
  logic [BIT_W-1:0]            bit_idx;
  logic                        load;
  logic                        sclk_d, sdo_d, strobe_d, clear_d;

  bcm_plane_store #(
    .N_CH(N_CH), .WORD_W(WORD_W), .N_BITS(N_BITS)
  ) u_store (
    .clk_i, .rst_ni, .wr_en_i, .wr_ch_i, .wr_data_i,
    .planes_o(planes)
  );

  bcm_sequencer #(
    .N_BITS(N_BITS), .SHIFT_TICKS(SHIFT_TICKS), .DATA_EXTRA(DATA_EXTRA),
    .BASE_TICKS(BASE_TICKS), .CLR_TICKS(CLR_TICKS)
  ) u_seq (
    .clk_i, .rst_ni,
    .phase_o(phase), .tick_o(tick), .bit_o(bit_idx), .load_o(load)
  );

  bcm_shifter #(
    .N_CH(N_CH), .N_BITS(N_BITS), .CNT_W(CNT_W)
  ) u_shift (
    .clk_i, .rst_ni,
    .load_i(load), .bit_i(bit_idx), .planes_i(planes),
    .phase_i(phase), .tick_i(tick),
    .sclk_o(sclk_d), .sdo_o(sdo_d)
  );

  // strobe holds to end of data cycle; clear waits DEAD_TICKS after it drops
  assign strobe_d = (phase == PH_DATA)  && (tick >= CNT_W'(SHIFT_TICKS));
  assign clear_d  = (phase == PH_CLEAR) && (tick == CNT_W'(DEAD_TICKS));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sclk_o   <= 1'b0;
      sdo_o    <= 1'b0;
      strobe_o <= 1'b0;
      clear_o  <= 1'b0;
    end else begin
      sclk_o   <= sclk_d;
      sdo_o    <= sdo_d;
      strobe_o <= strobe_d;
      clear_o  <= clear_d;
    end
  end

  // R7
  strobe_clear_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_o |-> (!strobe_o && $past(!strobe_o)));

  // R7
  clear_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_o |=> !clear_o);

  // R10
  sclk_strobe_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sclk_o |-> !strobe_o);

  // R4
  sdo_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sclk_o |-> $stable(sdo_o));
endmodule

// File: tb/bcm_led_driver_bench.sv
module bcm_led_driver_bench;
  localparam int NB   = 14;
  localparam int NCH  = 32;
  localparam int BASE = 1;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [4:0]  wr_ch = '0;
  logic [15:0] wr_data = '0;
  logic        sclk, sdo, strobe, clear;

  always #10 clk = ~clk;

  bcm_led_driver #(.BASE_TICKS(BASE)) u_bcm_led_driver (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_ch_i(wr_ch), .wr_data_i(wr_data),
    .sclk_o(sclk), .sdo_o(sdo), .strobe_o(strobe), .clear_o(clear)
  );

  int n_checks = 0, n_fail = 0;
  logic [15:0] model [NCH];

  // monitor, sampled on the falling edge
  longint cyc = 0, last_rise = 0, stb_fall = 0, clr_rise = 0;
  int stb_cnt = 0, fall_cnt = 0, clr_cnt = 0, nclk = 0;
  int rec_idx = 0, rec_nclk = 0, overlap = 0, sclk_bad = 0;
  longint rec_int = 0, rec_w = 0, rec_gap = 0, rec_cw = 0;
  logic [31:0] shreg = '0, rec_bits = '0;
  logic sclk_p = 0, stb_p = 0, clr_p = 0;

  always @(negedge clk) begin
    cyc++;
    if (sclk && !sclk_p) begin
      shreg = {shreg[30:0], sdo};
      nclk++;
      if (strobe) sclk_bad++;
    end
    if (strobe && !stb_p) begin
      rec_bits = shreg; rec_nclk = nclk; nclk = 0;
      rec_int = cyc - last_rise; last_rise = cyc;
      rec_idx = stb_cnt % NB; stb_cnt++;
    end
    if (!strobe && stb_p) begin
      rec_w = cyc - last_rise; stb_fall = cyc; fall_cnt++;
    end
    if (clear && !clr_p) begin
      rec_gap = cyc - stb_fall; clr_rise = cyc;
    end
    if (!clear && clr_p) begin
      rec_cw = cyc - clr_rise; clr_cnt++;
    end
    if (strobe && clear) overlap++;
    sclk_p = sclk; stb_p = strobe; clr_p = clear;
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_wire(input int p);
    logic [31:0] pl;
    for (int j = 0; j < NCH; j++) pl[j] = model[j][p+2];
    return {pl[15:0], pl[31:16]};
  endfunction

  task automatic wait_rise();
    int n = stb_cnt;
    while (stb_cnt == n) @(posedge clk);
  endtask
  task automatic wait_fall();
    int n = fall_cnt;
    while (fall_cnt == n) @(posedge clk);
  endtask
  task automatic wait_clr();
    int n = clr_cnt;
    while (clr_cnt == n) @(posedge clk);
  endtask

  task automatic write_ch(input int ch, input logic [15:0] v);
    @(negedge clk);
    wr_en = 1'b1; wr_ch = 5'(ch); wr_data = v;
    @(negedge clk);
    wr_en = 1'b0;
    model[ch] = v;
  endtask

  // R1: reset state and first plane
  task automatic t_reset();
    for (int j = 0; j < NCH; j++) model[j] = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk({sclk, sdo, strobe, clear} == 4'b0, "R1", "outputs in reset", {sclk, sdo, strobe, clear}, 0);
    rst_n = 1'b1;
    wait_rise();
    chk(rec_idx == 0 && rec_bits == 0, "R1", "first plane after reset", rec_bits, 0);
    wait_fall();
    chk(rec_w == 2 + BASE, "R1", "plane 0 strobe width", rec_w, 2 + BASE);
  endtask

  // one full frame starting at plane 0, all written data settled
  task automatic check_frame(input string tag);
    longint sum = 0;
    wait_clr();
    do wait_rise(); while (rec_idx != 0);
    for (int p = 0; p < NB; p++) begin
      int prev = (p + NB - 1) % NB;
      if (p > 0) wait_rise();
      chk(rec_idx == p, "R5", {tag, " plane order"}, rec_idx, p);
      chk(rec_bits == exp_wire(p), "R3", {tag, " plane bits/order (R4)"}, rec_bits, exp_wire(p));
      chk(rec_nclk == 32, "R4", {tag, " sclk rises"}, rec_nclk, 32);
      chk(rec_int == 162 + (BASE << prev), "R6", {tag, " period"}, rec_int, 162 + (BASE << prev));
      sum += rec_int;
      wait_fall();
      chk(rec_w == 2 + (BASE << p), "R6", {tag, " strobe width"}, rec_w, 2 + (BASE << p));
      wait_clr();
      chk(rec_cw == 1, "R7", {tag, " clear width"}, rec_cw, 1);
      chk(rec_gap == 1, "R7", {tag, " strobe-to-clear gap"}, rec_gap, 1);
    end
    chk(sum == 14 * 162 + BASE * ((1 << NB) - 1), "R8", {tag, " frame length"},
        sum, 14 * 162 + BASE * ((1 << NB) - 1));
  endtask

  // mixed pattern; R2: low bits set everywhere, channel 3 holds only low bits
  task automatic t_pattern();
    for (int j = 0; j < NCH; j++)
      write_ch(j, 16'((j * 16'h0A5C + 16'h1357) ^ (j << 9)) | 16'h0003);
    write_ch(3, 16'h0003);
    check_frame("mixed");
  endtask

  task automatic t_full();
    for (int j = 0; j < NCH; j++) write_ch(j, 16'hFFFF);
    check_frame("full");
  endtask

  // R9: write lands while a plane is shifting
  task automatic t_write_in_shift();
    int p, pn;
    logic [15:0] nv;
    logic [31:0] old_exp;
    wait_clr();
    p  = stb_cnt % NB;
    pn = (p + 1) % NB;
    old_exp = exp_wire(p);
    repeat (60) @(posedge clk);
    nv = model[5] ^ 16'(1 << (p + 2)) ^ 16'(1 << (pn + 2));
    write_ch(5, nv);
    wait_rise();
    chk(rec_bits == old_exp, "R9", "plane shifting during write", rec_bits, old_exp);
    wait_rise();
    chk(rec_bits == exp_wire(pn), "R9", "next plane after write", rec_bits, exp_wire(pn));
  endtask

  initial begin
    t_reset();
    t_pattern();
    t_write_in_shift();
    t_full();
    chk(overlap == 0, "R7", "strobe and clear together", overlap, 0);
    chk(sclk_bad == 0, "R10", "sclk rise under strobe", sclk_bad, 0);
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule